// File: doc/BRIEF.md
# Transmit Interrupt Status Generator

This block turns the status flags of one audio transmit channel into interrupt status. It keeps a small raw status vector with three live bits: a sticky underrun bit, a bit that follows the FIFO half-empty flag, and a transmit-complete bit. The transmit-complete bit is raised only when the FIFO is empty and the transmitter is idle. The raw vector is ANDed with an enable mask that software writes, and the result drives one level-sensitive interrupt line.

The underrun condition is held until software writes the clear register with the underrun-clear bit set. A read select returns the raw vector zero-extended onto the data bus. The block samples its inputs on every clock. A register write or a FIFO drain shows up in the status on the next edge, so the bits are re-evaluated after either kind of event. All pins are plain control and status signals with no handshake: a write strobe is taken in the cycle it is high.

Top module: `txi_status_gen`

## Requirements
- R1: An `ur_event` pulse sets the sticky underrun bit, raw bit 2, on the next clock edge. The bit then stays set until it is cleared as R5 describes.
- R2: Raw bit 1 equals the `half_empty` input sampled on the previous clock edge.
- R3: Raw bit 0, transmit complete, is 1 exactly when the previous edge saw `fifo_empty` high and `tx_busy` low.
- R4: `irq` is high whenever the raw vector ANDed with the enable mask is nonzero. The mask is written from `en_wdata[6:0]` when `en_wr` is high and takes effect on the next edge.
- R5: A clear write, `clr_wr` with `clr_wdata[0]` set, clears the underrun bit on the next edge. If `ur_event` is high in the same cycle, the bit stays set.
- R6: Bits of `clr_wdata` other than bit 0 have no effect on any status bit.
- R7: With `rd_sel` high, `rd_data` holds raw bits 6..0 in bits 6..0 and zeros above. With `rd_sel` low, `rd_data` is zero.
- R8: Reset clears the raw vector, the enable mask and the underrun bit, so `irq` is low after reset.
- R9: Raw bits 6..3 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ur_event | input | 1 | Underrun event from the FIFO (FIFO drained to empty) |
| half_empty | input | 1 | FIFO half-empty flag |
| fifo_empty | input | 1 | FIFO empty flag |
| tx_busy | input | 1 | Transmitter busy flag |
| en_wr | input | 1 | Enable mask write strobe |
| en_wdata | input | 32 | Enable mask write data |
| clr_wr | input | 1 | Clear register write strobe |
| clr_wdata | input | 32 | Clear register write data (bit 0 clears underrun) |
| rd_sel | input | 1 | Selects the interrupt readback onto rd_data |
| raw_status | output | 7 | Raw interrupt status vector |
| irq | output | 1 | Masked, level-sensitive interrupt line |
| rd_data | output | 32 | Readback of the raw status |

## Verification
Every combination of the four status inputs is applied together with a clear write, which may set the clear bit, the other bits, or neither. That full set of combinations is repeated under each of the eight enable masks over the live bits. The empty/busy pairs separate the transmit-complete term from its two inputs taken alone. Cycles that raise an underrun event and clear it at once separate the set-wins rule from a plain clear. Cycles that write only the non-clear bits show that the underrun bit survives them. Toggling the read select against the same states separates gating of the readback from the status itself.

// File: rtl/txi_pkg.sv
package txi_pkg;
  localparam int RAW_W   = 7;
  localparam int BUS_W   = 32;
  localparam int B_TXC   = 0;
  localparam int B_HE    = 1;
  localparam int B_UR    = 2;
  localparam int CLR_UR  = 0;
  localparam int LIVE_W  = 3;
  typedef logic [RAW_W-1:0] raw_t;
endpackage

// File: rtl/txi_ur_sticky.sv
module txi_ur_sticky
  import txi_pkg::*;
#(
  parameter int BW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_evt,
  input  logic          clr_wr,
  input  logic [BW-1:0] clr_wdata,
  output logic          ur_q,
  output logic          ur_next
);
  logic clr_hit;
  assign clr_hit = clr_wr & clr_wdata[CLR_UR];

  // set dominates a same-cycle clear
  assign ur_next = set_evt | (ur_q & ~clr_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) ur_q <= 1'b0;
    else        ur_q <= ur_next;
  end

  a_r1_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ur_q && !clr_hit) |=> ur_q);
  a_r5_clear_wins_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !set_evt) |=> !ur_q);
  a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> ur_q);
endmodule

// File: rtl/txi_raw_eval.sv
module txi_raw_eval
  import txi_pkg::*;
#(
  parameter int RW = RAW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ur_next,
  input  logic          half_empty,
  input  logic          fifo_empty,
  input  logic          tx_busy,
  output logic [RW-1:0] raw_q
);
  logic [RW-1:0] raw_d;

  always_comb begin
    raw_d        = '0;
    raw_d[B_TXC] = fifo_empty & ~tx_busy;
    raw_d[B_HE]  = half_empty;
    raw_d[B_UR]  = ur_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  a_r3_txc_needs_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !tx_busy) |=> raw_q[B_TXC]);
  a_r3_txc_clear_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> !raw_q[B_TXC]);
  a_r2_he_follows: assert property (@(posedge clk) disable iff (!rst_n)
    half_empty |=> raw_q[B_HE]);
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q[RW-1:LIVE_W] == '0);
endmodule

// File: rtl/txi_irq_mask.sv
module txi_irq_mask
  import txi_pkg::*;
#(
  parameter int RW = RAW_W,
  parameter int BW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_wr,
  input  logic [BW-1:0] en_wdata,
  input  logic [RW-1:0] raw,
  output logic          irq
);
  logic [RW-1:0] en_q;
  logic [RW-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata[RW-1:0];
  end

  for (genvar i = 0; i < RW; i++) begin : g_mask
    assign hit[i] = raw[i] & en_q[i];
  end

  assign irq = |hit;

  a_r4_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
  a_r4_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && en_wdata[RW-1:0] == '0) |=> !irq);
endmodule

// File: rtl/txi_status_gen.sv
module txi_status_gen
  import txi_pkg::*;
#(
  parameter int RW = RAW_W,
  parameter int BW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ur_event,
  input  logic          half_empty,
  input  logic          fifo_empty,
  input  logic          tx_busy,
  input  logic          en_wr,
  input  logic [BW-1:0] en_wdata,
  input  logic          clr_wr,
  input  logic [BW-1:0] clr_wdata,
  input  logic          rd_sel,
  output logic [RW-1:0] raw_status,
  output logic          irq,
  output logic [BW-1:0] rd_data
);
  logic ur_q;
  logic ur_next;

  txi_ur_sticky #(.BW(BW)) u_ur (
    .clk(clk), .rst_n(rst_n), .set_evt(ur_event),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .ur_q(ur_q), .ur_next(ur_next)
  );

  txi_raw_eval #(.RW(RW)) u_raw (
    .clk(clk), .rst_n(rst_n), .ur_next(ur_next),
    .half_empty(half_empty), .fifo_empty(fifo_empty), .tx_busy(tx_busy),
    .raw_q(raw_status)
  );

  txi_irq_mask #(.RW(RW), .BW(BW)) u_irq (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .raw(raw_status), .irq(irq)
  );

  assign rd_data = rd_sel ? {{(BW-RW){1'b0}}, raw_status} : '0;

  a_r7_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> (rd_data == '0));
  a_r1_raw_tracks_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    raw_status[B_UR] == ur_q);
endmodule

// File: tb/txi_status_gen_tb.sv
module txi_status_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ur_event = 1'b0, half_empty = 1'b0, fifo_empty = 1'b0, tx_busy = 1'b0;
  logic        en_wr = 1'b0, clr_wr = 1'b0, rd_sel = 1'b0;
  logic [31:0] en_wdata = '0, clr_wdata = '0;
  logic [6:0]  raw_status;
  logic        irq;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic       ur_m = 1'b0;
  logic [6:0] raw_m = '0;
  logic [6:0] en_m = '0;

  always #2 clk = ~clk;

  txi_status_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ur_event(ur_event), .half_empty(half_empty),
    .fifo_empty(fifo_empty), .tx_busy(tx_busy), .en_wr(en_wr), .en_wdata(en_wdata),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata), .rd_sel(rd_sel),
    .raw_status(raw_status), .irq(irq), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int pat, input logic wr_en, input logic [6:0] en_val);
    half_empty = pat[0];
    fifo_empty = pat[1];
    tx_busy    = pat[2];
    ur_event   = pat[3];
    clr_wr     = pat[4] | pat[5];
    clr_wdata  = (pat[4] ? 32'h1 : 32'h0) | (pat[5] ? 32'hFFFF_FFFE : 32'h0);
    rd_sel     = pat[0] ^ pat[2] ^ pat[4];
    en_wr      = wr_en;
    en_wdata   = {25'h1ABCDEF, en_val};
    @(posedge clk);
    ur_m  = pat[3] | (ur_m & ~pat[4]);
    raw_m = {4'b0, ur_m, pat[0], pat[1] & ~pat[2]};
    if (wr_en) en_m = en_val;
    @(negedge clk);
    chk("R1/R5/R6 underrun bit", 32'(raw_status[2]), 32'(raw_m[2]));
    chk("R2 half-empty bit", 32'(raw_status[1]), 32'(raw_m[1]));
    chk("R3 tx-complete bit", 32'(raw_status[0]), 32'(raw_m[0]));
    chk("R9 upper bits", 32'(raw_status[6:3]), 32'h0);
    chk("R4 irq", 32'(irq), 32'(|(raw_m & en_m)));
    chk("R7 readback", rd_data, rd_sel ? {25'h0, raw_m} : 32'h0);
    en_wr = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ur_event = 1'b1; fifo_empty = 1'b1; half_empty = 1'b1;
    en_wr = 1'b1; en_wdata = 32'h7F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_sel = 1'b1;
    chk("R8 reset raw", 32'(raw_status), 32'h0);
    chk("R8 reset irq", 32'(irq), 32'h0);
    chk("R8 reset readback", rd_data, 32'h0);
    ur_event = 1'b0; en_wr = 1'b0;
    rst_n = 1'b1;
    // enable mask still zero after reset: irq must stay low
    step(3, 1'b0, 7'h0);
    chk("R8 mask cleared by reset", 32'(irq), 32'h0);
    for (int e = 0; e < 8; e++) begin
      step(0, 1'b1, 7'(e));
      for (int p = 0; p < 64; p++) step(p, 1'b0, 7'h0);
    end
    // clear with upper bits only leaves underrun set (R6)
    step(8, 1'b1, 7'h4);
    step(32, 1'b0, 7'h0);
    chk("R6 upper clear bits ignored", 32'(irq), 32'h1);
    // simultaneous set and clear keeps underrun (R5)
    step(24, 1'b0, 7'h0);
    chk("R5 set wins", 32'(raw_status[2]), 32'h1);
    step(16, 1'b0, 7'h0);
    chk("R5 clear", 32'(raw_status[2]), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule